// File: doc/BRIEF.md
# Quiet-Line Loss-of-Signal Monitor

This block watches one serial input bit for edges and drives a flag that is high while the line has been silent. It is clocked by the crystal reference of the receiver (14.140 MHz nominal). A prescaler divides that clock into a coarse window tick of about 5 µs. Between ticks, a sticky latch records whether any edge was seen. At each tick the latch is inspected and then cleared. A tick that closes a silent window raises the flag. Any edge seen while the flag is high drops it at the next tick.

The asymmetric timing comes from this coarse tick. The flag cannot rise sooner than one full window after the last edge, and it always rises within two windows. Release happens within one window. The serial input is asynchronous to the reference clock, so it passes through a two-stage synchronizer before edge detection. No attempt is made to tell data from noise: a single glitch of one reference period counts as activity.

Top module: `quiet_line_monitor`

## Requirements
- R1: The flag `lossFlag` is active high. It is low while `rstN` is low, including when reset is applied in the middle of operation with the flag high. It is low on the first cycle after reset is released.
- R2: The window tick repeats every `TICK_CYCLES` (default 71) reference cycles, which is about 5.02 µs at 14.140 MHz. Reset clears the prescaler and the edge latch. With a constant input, the flag is therefore still low 70 cycles after reset release and high 71 cycles after it.
- R3: `lossFlag` changes only on a tick edge. Counted from reset release, the cycle index of any change is a multiple of `TICK_CYCLES`.
- R4: The flag rises at the first tick that closes a window with no edge. Measured from the last input edge, it stays low for at least 72 cycles (5 µs) and is high no later than 150 cycles (10 µs plus synchronizer latency). Once high, it stays high while the line stays quiet.
- R5: While the flag is high, an input edge clears it at the next tick. The flag is low 80 cycles after the edge when the line stays active.
- R6: Rising and falling edges both count as activity. A pulse one reference cycle wide also counts as activity.
- R7: The idle level of the line has no effect. Silence held at 1 and silence held at 0 both raise the flag within the R4 bound.
- R8: Edges spaced 60 cycles apart keep the flag low throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Crystal reference clock, 14.140 MHz nominal |
| rstN | input | 1 | Asynchronous active-low reset |
| serialIn | input | 1 | Monitored serial line, asynchronous to refClk |
| lossFlag | output | 1 | High while the line is judged silent |

## Verification
The line is driven with several kinds of activity:
- Alternating single edges with gaps of 40, 60 and 72 cycles. These show that short silences never raise the flag, and that the rising and falling edges of the line are each detected.
- Gaps of 150 cycles, ending once at each idle level. These show that the flag always rises before the upper bound, whatever level the line rests at.
- One-cycle pulses. These separate an edge detector that sees real glitches from one that filters them.
- A long hold and a reset during loss. These confirm that the flag holds while the line is quiet and is cleared by reset.

A monitor logs the cycle of every flag change and checks that each one falls on the tick grid.

// File: rtl/qlm_pkg.sv
package qlm_pkg;

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic windowClose;   // tick: latch is examined and cleared this cycle
  } ctrlStrobes_t;

  // Activity status from the datapath to the control section.
  typedef struct packed {
    logic edgeNow;       // synchronized edge detected this cycle
    logic edgeLatched;   // edge seen earlier in the current window
  } dpStatus_t;

endpackage

// File: rtl/qlm_datapath.sv
module qlm_datapath
  import qlm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         refClk,
  input  logic         rstN,
  input  logic         serialIn,
  input  ctrlStrobes_t strobes,
  output dpStatus_t    status
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [LAST_STAGE:0] syncChain;
  logic                prevLevel;
  logic                edgeSeen;
  logic                edgeNow;

  // Synchronizer chain. Stage 0 samples the asynchronous line.
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge refClk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= serialIn;
        end
      end else begin : g_rest
        always_ff @(posedge refClk or negedge rstN) begin
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  // Edge detector: either polarity counts.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= syncChain[LAST_STAGE];
  end

  assign edgeNow = syncChain[LAST_STAGE] ^ prevLevel;

  // Sticky activity latch, cleared at each window close.
  // An edge that lands on the tick cycle is reported through edgeNow,
  // so clearing the latch on that cycle loses nothing.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                    edgeSeen <= 1'b0;
    else if (strobes.windowClose) edgeSeen <= 1'b0;
    else if (edgeNow)             edgeSeen <= 1'b1;
  end

  assign status.edgeNow     = edgeNow;
  assign status.edgeLatched = edgeSeen;

endmodule

// File: rtl/qlm_control.sv
module qlm_control
  import qlm_pkg::*;
#(
  parameter int TICK_CYCLES     = 71,
  parameter int QUIET_INTERVALS = 1
) (
  input  logic         refClk,
  input  logic         rstN,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         lossFlag
);

  localparam int CNT_W   = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int QUIET_W = $clog2(QUIET_INTERVALS + 1);
  localparam logic [CNT_W-1:0]   CNT_LAST  = CNT_W'(TICK_CYCLES - 1);
  localparam logic [QUIET_W-1:0] QUIET_MAX = QUIET_W'(QUIET_INTERVALS);

  logic [CNT_W-1:0]   preCount;
  logic [QUIET_W-1:0] quietRun;
  logic [QUIET_W-1:0] quietNext;
  logic               tick;
  logic               activity;
  logic               flagReg;

  // Prescaler: one tick every TICK_CYCLES reference cycles.
  assign tick = (preCount == CNT_LAST);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)     preCount <= '0;
    else if (tick) preCount <= '0;
    else           preCount <= preCount + 1'b1;
  end

  assign activity  = status.edgeNow | status.edgeLatched;
  assign quietNext = (quietRun == QUIET_MAX) ? quietRun : quietRun + 1'b1;

  // Count consecutive silent windows. The flag follows the count.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      quietRun <= '0;
      flagReg  <= 1'b0;
    end else if (tick) begin
      if (activity) begin
        quietRun <= '0;
        flagReg  <= 1'b0;
      end else begin
        quietRun <= quietNext;
        flagReg  <= (quietNext == QUIET_MAX);
      end
    end
  end

  assign strobes.windowClose = tick;
  assign lossFlag            = flagReg;

endmodule

// File: rtl/quiet_line_monitor.sv
module quiet_line_monitor
  import qlm_pkg::*;
#(
  parameter int TICK_CYCLES     = 71,
  parameter int QUIET_INTERVALS = 1,
  parameter int SYNC_STAGES     = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic serialIn,
  output logic lossFlag
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;
  logic         tickW;
  logic         activityW;

  qlm_datapath #(
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .refClk   (refClk),
    .rstN     (rstN),
    .serialIn (serialIn),
    .strobes  (strobes),
    .status   (status)
  );

  qlm_control #(
    .TICK_CYCLES     (TICK_CYCLES),
    .QUIET_INTERVALS (QUIET_INTERVALS)
  ) ctl_i (
    .refClk   (refClk),
    .rstN     (rstN),
    .status   (status),
    .strobes  (strobes),
    .lossFlag (lossFlag)
  );

  // Plain nets for the bound checker.
  assign tickW     = strobes.windowClose;
  assign activityW = status.edgeNow | status.edgeLatched;

endmodule

// File: rtl/qlm_checker.sv
module qlm_checker #(
  parameter int TICK_CYCLES     = 71,
  parameter int QUIET_INTERVALS = 1
) (
  input logic refClk,
  input logic rstN,
  input logic lossFlag,
  input logic tickW,
  input logic activityW
);

  int unsigned sinceTick;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)      sinceTick <= 0;
    else if (tickW) sinceTick <= 0;
    else            sinceTick <= sinceTick + 1;
  end

  AST_RESET_CLEAR: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(rstN) |-> !lossFlag);  // R1

  AST_TICK_SPACING: assert property (@(posedge refClk) disable iff (!rstN)
    tickW |-> (sinceTick == TICK_CYCLES - 1));  // R2

  AST_TICK_DUE: assert property (@(posedge refClk) disable iff (!rstN)
    (sinceTick == TICK_CYCLES - 1) |-> tickW);  // R2

  AST_FLAG_ON_GRID: assert property (@(posedge refClk) disable iff (!rstN)
    !$stable(lossFlag) |-> $past(tickW));  // R3

  AST_QUIET_RAISES: assert property (@(posedge refClk) disable iff (!rstN)
    (QUIET_INTERVALS == 1) && tickW && !activityW |=> lossFlag);  // R4

  AST_ACTIVE_CLEARS: assert property (@(posedge refClk) disable iff (!rstN)
    tickW && activityW |=> !lossFlag);  // R5

endmodule

bind quiet_line_monitor qlm_checker #(
  .TICK_CYCLES     (TICK_CYCLES),
  .QUIET_INTERVALS (QUIET_INTERVALS)
) chk_i (
  .refClk    (refClk),
  .rstN      (rstN),
  .lossFlag  (lossFlag),
  .tickW     (tickW),
  .activityW (activityW)
);

// File: tb/quiet_line_monitor_tb.sv
`timescale 1ns/1ps
module quiet_line_monitor_tb_top;

  localparam int CLK_PERIOD = 70;
  localparam int TICK       = 71;
  localparam int WATCHDOG   = 200000;

  typedef struct packed {
    logic       isPulse;  // 1: one-cycle pulse, 0: single toggle
    logic [7:0] gap;      // cycles from the start of the stimulus to the sample
    logic       doCheck;
    logic       expFlag;
    logic [3:0] req;
  } vec_t;

  // Walked in order. Each row's expected value depends on the rows before it.
  localparam vec_t VECS [12] = '{
    '{1'b0, 8'd40,  1'b0, 1'b0, 4'd5},  // R5 edge while flagged, no sample yet
    '{1'b0, 8'd40,  1'b1, 1'b0, 4'd5},  // R5 released
    '{1'b0, 8'd60,  1'b1, 1'b0, 4'd8},  // R8 steady edges
    '{1'b0, 8'd60,  1'b1, 1'b0, 4'd8},  // R8
    '{1'b0, 8'd60,  1'b1, 1'b0, 4'd6},  // R6 both polarities
    '{1'b0, 8'd72,  1'b1, 1'b0, 4'd4},  // R4 lower bound
    '{1'b0, 8'd150, 1'b1, 1'b1, 4'd4},  // R4 upper bound, idle at 1
    '{1'b0, 8'd150, 1'b1, 1'b1, 4'd7},  // R7 idle at 0
    '{1'b1, 8'd40,  1'b0, 1'b0, 4'd6},  // R6 pulse
    '{1'b1, 8'd40,  1'b1, 1'b0, 4'd6},  // R6 pulses release the flag
    '{1'b1, 8'd72,  1'b1, 1'b0, 4'd6},  // R6 pulse counts as recent activity
    '{1'b1, 8'd150, 1'b1, 1'b1, 4'd4}   // R4 after a pulse
  };

  logic refClk = 1'b0;
  logic rstN;
  logic serialIn;
  logic lossFlag;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  logic monOn = 1'b0;
  logic prevFlag = 1'b0;

  quiet_line_monitor dut_i (
    .refClk   (refClk),
    .rstN     (rstN),
    .serialIn (serialIn),
    .lossFlag (lossFlag)
  );

  always #(CLK_PERIOD/2) refClk = ~refClk;

  // Bench-side cycle count since reset release.
  always @(posedge refClk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lossFlag=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // R3: every flag change falls on the tick grid measured from reset release.
  always @(negedge refClk) begin
    if (monOn && rstN) begin
      if (lossFlag !== prevFlag) begin
        checks++;
        if ((cyc % TICK) != 0) begin
          errors++;
          $display("FAIL R3: flag changed at cycle %0d, expected a multiple of %0d", cyc, TICK);
        end
      end
    end
    prevFlag = lossFlag;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finishRun();
  end

  initial begin
    rstN     = 1'b0;
    serialIn = 1'b0;
    waitCycles(5);
    check(lossFlag, 1'b0, "R1");               // R1 low in reset
    rstN = 1'b1;
    monOn = 1'b1;
    waitCycles(1);
    check(lossFlag, 1'b0, "R1");               // R1 low just after release
    waitCycles(69);
    check(lossFlag, 1'b0, "R2");               // R2 70 cycles: no tick yet
    waitCycles(1);
    check(lossFlag, 1'b1, "R2");               // R2 first tick at 71

    for (int i = 0; i < 12; i++) begin
      serialIn = ~serialIn;
      if (VECS[i].isPulse) begin
        waitCycles(1);
        serialIn = ~serialIn;
        waitCycles(int'(VECS[i].gap) - 1);
      end else begin
        waitCycles(int'(VECS[i].gap));
      end
      if (VECS[i].doCheck)
        check(lossFlag, VECS[i].expFlag, $sformatf("R%0d", VECS[i].req));
    end

    // R4: the flag holds while the line stays quiet.
    for (int k = 0; k < 4; k++) begin
      waitCycles(50);
      check(lossFlag, 1'b1, "R4");
    end

    // R1: reset in the middle of a loss clears the flag at once.
    monOn = 1'b0;
    #(CLK_PERIOD/4);
    rstN = 1'b0;
    #1;
    check(lossFlag, 1'b0, "R1");
    waitCycles(3);
    rstN = 1'b1;
    monOn = 1'b1;
    waitCycles(70);
    check(lossFlag, 1'b0, "R2");
    waitCycles(1);
    check(lossFlag, 1'b1, "R2");

    finishRun();
  end

endmodule